// File: doc/BRIEF.md
# Supply Supervisor with Watchdog

This block is a clocked model of a processor supervisor. An external comparator supplies a digital supply-good flag. The block also takes an active-low manual-reset line and a watchdog strobe. From these it drives a reset in two polarities and an active-low watchdog alarm. A reset is raised while the supply is bad or while a qualified manual-reset press is held. Once the cause has gone, the reset is held for a fixed stretch time, `STRETCH_CYC` clock cycles. The default is 140 ms at 50 MHz. The stretch also absorbs switch bounce on the manual-reset line, so that line has no debounce filter of its own. Thresholds, references and hysteresis stay outside the block.

The three asynchronous inputs pass through two-flop synchronisers. Three state machines work on the synchronised values.

The manual-reset qualifier has three states:
- `MQ_IDLE`: the line is high.
- `MQ_TIMING`: counting consecutive low samples.
- `MQ_ACCEPT`: the press is accepted.

Its transitions:
- IDLE to TIMING on the first low sample. With `MR_MIN_CYC` = 1 this step goes straight to ACCEPT.
- TIMING to ACCEPT on the `MR_MIN_CYC`-th consecutive low sample.
- TIMING or ACCEPT back to IDLE on a high sample.

The reset machine has three states: `RS_HOLD` (a cause is present), `RS_STRETCH` (counting down the stretch) and `RS_RUN` (released). Its transitions:
- Any state to HOLD whenever the cause is present.
- HOLD to STRETCH when the cause clears. This loads the counter.
- STRETCH to RUN when the counter has reached zero.
- Power-on reset puts the machine in STRETCH with the counter loaded.

The watchdog has three states: `WD_IDLE` (held during reset), `WD_COUNT` and `WD_EXPIRED`. Its transitions:
- IDLE to COUNT when reset releases.
- COUNT to EXPIRED after `WD_TIMEOUT_CYC` cycles without a strobe edge. Any strobe edge restarts the count.
- EXPIRED to COUNT on a strobe edge.
- COUNT or EXPIRED to IDLE when reset asserts.

The alarm is low in EXPIRED. It is also low, regardless of state, whenever the synchronised supply-good flag is low.

Top module: `supply_supervisor`

## Requirements
- R1: From power-on reset with the supply good, `rst_hi` is 1 during power-on reset and falls exactly `STRETCH_CYC`+3 clock edges after `por_n` releases.
- R2: `rst_lo_n` is at all times the exact complement of `rst_hi`.
- R3: When `supply_ok` falls, `rst_hi` rises on the third clock edge after the change and stays 1 for as long as the supply stays bad.
- R4: When `supply_ok` returns high, `rst_hi` falls exactly `STRETCH_CYC`+3 edges later.
- R5: A manual-reset low pulse of W sampled cycles is accepted if and only if W >= `MR_MIN_CYC`. An accepted pulse raises `rst_hi` `MR_MIN_CYC`+3 edges after `mr_n` falls. The manual-reset synchroniser leaves power-on reset reading high (inactive).
- R6: After an accepted press, `rst_hi` falls exactly `STRETCH_CYC`+4 edges after `mr_n` returns high.
- R7: Low pulses on `mr_n` shorter than `MR_MIN_CYC` during the stretch neither restart it nor release it: `rst_hi` stays 1 and falls at the time R6 gives for the original press.
- R8: When `supply_ok` falls, `wdo_n` goes low two edges after the change, one cycle before `rst_hi` rises, even if the watchdog was freshly served.
- R9: Strobe edges spaced at most `WD_TIMEOUT_CYC` cycles apart keep `wdo_n` high. With spacings of `WD_TIMEOUT_CYC`+1 or more, `wdo_n` goes low. `wdo_n` falls `WD_TIMEOUT_CYC`+3 edges after the last strobe toggle.
- R10: An expired watchdog returns `wdo_n` high three edges after a strobe toggle. It also returns high one edge after `rst_hi` rises, if the supply is good.
- R11: The watchdog is held cleared during reset. After `rst_hi` falls, with no strobe activity, `wdo_n` goes low exactly `WD_TIMEOUT_CYC`+1 edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Asynchronous power-on reset of the logic, active low |
| supply_ok | input | 1 | Digital supply-good flag from the external comparator, asynchronous |
| mr_n | input | 1 | Manual reset, active low, asynchronous |
| wd_strobe | input | 1 | Watchdog strobe; each edge serves the watchdog |
| rst_hi | output | 1 | Reset, active high |
| rst_lo_n | output | 1 | Reset, active low, complement of `rst_hi` |
| wdo_n | output | 1 | Watchdog alarm, active low |

## Verification
Manual-reset pulse widths are swept on both sides of `MR_MIN_CYC`. A qualifier that is off by one would either accept a pulse one cycle short or reject one of exactly the minimum width. The release instants after supply loss, power-up and manual reset are timed to the edge. A stretch counter that loads N instead of N-1, or that reloads on bounce, shows up as a wrong fall time or as a dropout in the middle of the pulse. Strobe periods are swept around `WD_TIMEOUT_CYC`. The watchdog is checked after a long reset, where a counter that kept running during reset would expire early. On supply loss the bench checks that the alarm falls one cycle ahead of the reset. A design that gated the alarm through the reset path would show both changing together.

// File: rtl/supv_pkg.sv
package supv_pkg;

    typedef enum logic [1:0] {
        RS_HOLD    = 2'd0,
        RS_STRETCH = 2'd1,
        RS_RUN     = 2'd2
    } rst_state_e;

    typedef enum logic [1:0] {
        WD_IDLE    = 2'd0,
        WD_COUNT   = 2'd1,
        WD_EXPIRED = 2'd2
    } wd_state_e;

    typedef enum logic [1:0] {
        MQ_IDLE   = 2'd0,
        MQ_TIMING = 2'd1,
        MQ_ACCEPT = 2'd2
    } mq_state_e;

    // Bits needed to hold values 0..n
    function automatic int cnt_width(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic por_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/supv_mr_qual.sv
module supv_mr_qual
    import supv_pkg::*;
#(
    parameter int MIN_CYC = 25
) (
    input  logic clk,
    input  logic por_n,
    input  logic mr_s,
    output logic mr_act
);

    localparam int            CW   = cnt_width(MIN_CYC);
    localparam logic [CW-1:0] LAST = CW'(MIN_CYC - 1);

    mq_state_e     state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= MQ_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            MQ_IDLE: begin
                if (!mr_s) begin
                    if (MIN_CYC <= 1) begin
                        nxt = MQ_ACCEPT;
                    end else begin
                        nxt     = MQ_TIMING;
                        cnt_nxt = CW'(1);
                    end
                end
            end
            MQ_TIMING: begin
                if (mr_s) begin
                    nxt     = MQ_IDLE;
                    cnt_nxt = '0;
                end else if (cnt == LAST) begin
                    nxt = MQ_ACCEPT;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            MQ_ACCEPT: begin
                if (mr_s) begin
                    nxt     = MQ_IDLE;
                    cnt_nxt = '0;
                end
            end
            default: begin
                nxt     = MQ_IDLE;
                cnt_nxt = '0;
            end
        endcase
    end

    always_comb begin
        mr_act = (state == MQ_ACCEPT);
    end

endmodule

// File: rtl/supv_reset_fsm.sv
module supv_reset_fsm
    import supv_pkg::*;
#(
    parameter int STRETCH_CYC = 7_000_000
) (
    input  logic clk,
    input  logic por_n,
    input  logic cause,
    output logic rst_hi
);

    localparam int            CW   = cnt_width(STRETCH_CYC);
    localparam logic [CW-1:0] LOAD = CW'(STRETCH_CYC - 1);

    rst_state_e    state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= RS_STRETCH;
            cnt   <= LOAD;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            RS_HOLD: begin
                if (!cause) begin
                    nxt     = RS_STRETCH;
                    cnt_nxt = LOAD;
                end
            end
            RS_STRETCH: begin
                if (cause) begin
                    nxt = RS_HOLD;
                end else if (cnt == '0) begin
                    nxt = RS_RUN;
                end else begin
                    cnt_nxt = cnt - 1'b1;
                end
            end
            RS_RUN: begin
                if (cause) begin
                    nxt = RS_HOLD;
                end
            end
            default: nxt = RS_HOLD;
        endcase
    end

    always_comb begin
        rst_hi = (state != RS_RUN);
    end

endmodule

// File: rtl/supv_watchdog.sv
module supv_watchdog
    import supv_pkg::*;
#(
    parameter int TIMEOUT_CYC = 80_000_000
) (
    input  logic clk,
    input  logic por_n,
    input  logic strobe_s,
    input  logic rst_hi,
    input  logic sup_s,
    output logic wdo_n
);

    localparam int            CW   = cnt_width(TIMEOUT_CYC);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

    wd_state_e     state, nxt;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          strobe_d;
    logic          kick;

    assign kick = strobe_s ^ strobe_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state    <= WD_IDLE;
            cnt      <= '0;
            strobe_d <= 1'b0;
        end else begin
            state    <= nxt;
            cnt      <= cnt_nxt;
            strobe_d <= strobe_s;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            WD_IDLE: begin
                cnt_nxt = '0;
                if (!rst_hi) begin
                    nxt = WD_COUNT;
                end
            end
            WD_COUNT: begin
                if (rst_hi) begin
                    nxt     = WD_IDLE;
                    cnt_nxt = '0;
                end else if (kick) begin
                    cnt_nxt = '0;
                end else if (cnt == LAST) begin
                    nxt = WD_EXPIRED;
                end else begin
                    cnt_nxt = cnt + 1'b1;
                end
            end
            WD_EXPIRED: begin
                cnt_nxt = '0;
                if (rst_hi) begin
                    nxt = WD_IDLE;
                end else if (kick) begin
                    nxt = WD_COUNT;
                end
            end
            default: begin
                nxt     = WD_IDLE;
                cnt_nxt = '0;
            end
        endcase
    end

    always_comb begin
        wdo_n = (state != WD_EXPIRED) && sup_s;
    end

endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor #(
    parameter int STRETCH_CYC    = 7_000_000,
    parameter int MR_MIN_CYC     = 25,
    parameter int WD_TIMEOUT_CYC = 80_000_000,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic supply_ok,
    input  logic mr_n,
    input  logic wd_strobe,
    output logic rst_hi,
    output logic rst_lo_n,
    output logic wdo_n
);

    localparam int         N_IN     = 3;
    localparam logic [2:0] SYNC_RST = 3'b010;

    logic [N_IN-1:0] raw_in;
    logic [N_IN-1:0] synced;
    logic            sup_s;
    logic            mr_s;
    logic            strobe_s;
    logic            mr_act;
    logic            reset_cause;

    assign raw_in = {wd_strobe, mr_n, supply_ok};

    for (genvar i = 0; i < N_IN; i++) begin : g_sync
        supv_sync #(
            .STAGES   (SYNC_STAGES),
            .RESET_VAL(SYNC_RST[i])
        ) u_sync (
            .clk  (clk),
            .por_n(por_n),
            .d    (raw_in[i]),
            .q    (synced[i])
        );
    end

    assign sup_s    = synced[0];
    assign mr_s     = synced[1];
    assign strobe_s = synced[2];

    supv_mr_qual #(
        .MIN_CYC(MR_MIN_CYC)
    ) u_mr (
        .clk   (clk),
        .por_n (por_n),
        .mr_s  (mr_s),
        .mr_act(mr_act)
    );

    assign reset_cause = !sup_s || mr_act;

    supv_reset_fsm #(
        .STRETCH_CYC(STRETCH_CYC)
    ) u_rst (
        .clk   (clk),
        .por_n (por_n),
        .cause (reset_cause),
        .rst_hi(rst_hi)
    );

    assign rst_lo_n = !rst_hi;

    supv_watchdog #(
        .TIMEOUT_CYC(WD_TIMEOUT_CYC)
    ) u_wd (
        .clk     (clk),
        .por_n   (por_n),
        .strobe_s(strobe_s),
        .rst_hi  (rst_hi),
        .sup_s   (sup_s),
        .wdo_n   (wdo_n)
    );

endmodule

// File: rtl/supply_supervisor_chk.sv
module supply_supervisor_chk #(
    parameter int STRETCH_CYC = 7_000_000,
    parameter int MR_MIN_CYC  = 25
) (
    input logic clk,
    input logic por_n,
    input logic supply_ok,
    input logic sup_s,
    input logic mr_s,
    input logic reset_cause,
    input logic rst_hi,
    input logic rst_lo_n,
    input logic wdo_n
);

    localparam int SCW = $clog2(STRETCH_CYC + 2);
    localparam int MCW = $clog2(MR_MIN_CYC + 2);

    logic [SCW-1:0] free_cnt;
    logic [MCW-1:0] low_run;

    // cycles spent in reset with no cause present
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            free_cnt <= '0;
        end else if (reset_cause || !rst_hi) begin
            free_cnt <= '0;
        end else if (free_cnt != SCW'(STRETCH_CYC + 1)) begin
            free_cnt <= free_cnt + 1'b1;
        end
    end

    // consecutive low samples of the synchronised manual reset
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            low_run <= '0;
        end else if (mr_s) begin
            low_run <= '0;
        end else if (low_run != MCW'(MR_MIN_CYC)) begin
            low_run <= low_run + 1'b1;
        end
    end

    a_r2_complement: assert property (@(posedge clk) disable iff (!por_n)
        rst_hi == !rst_lo_n);

    a_r3_supply_loss: assert property (@(posedge clk) disable iff (!por_n)
        !sup_s |=> rst_hi);

    a_r4_stretch_len: assert property (@(posedge clk) disable iff (!por_n)
        $fell(rst_hi) |-> $past(free_cnt) == SCW'(STRETCH_CYC));

    a_r5_mr_width: assert property (@(posedge clk) disable iff (!por_n)
        ($rose(rst_hi) && $past(sup_s)) |-> $past(low_run) >= MCW'(MR_MIN_CYC));

    a_r8_wdo_on_loss: assert property (@(posedge clk) disable iff (!por_n)
        $fell(supply_ok) |-> ##2 !wdo_n);

    a_r11_held_in_reset: assert property (@(posedge clk) disable iff (!por_n)
        ($past(rst_hi) && rst_hi && sup_s) |-> wdo_n);

endmodule

bind supply_supervisor supply_supervisor_chk #(
    .STRETCH_CYC(STRETCH_CYC),
    .MR_MIN_CYC (MR_MIN_CYC)
) u_chk (
    .clk        (clk),
    .por_n      (por_n),
    .supply_ok  (supply_ok),
    .sup_s      (sup_s),
    .mr_s       (mr_s),
    .reset_cause(reset_cause),
    .rst_hi     (rst_hi),
    .rst_lo_n   (rst_lo_n),
    .wdo_n      (wdo_n)
);

// File: tb/tb_supply_supervisor.sv
`timescale 1ns/1ps
module tb_supply_supervisor;

    localparam int N = 20;
    localparam int M = 4;
    localparam int T = 12;

    logic clk = 1'b0;
    logic por_n, supply_ok, mr_n, wd_strobe;
    logic rst_hi, rst_lo_n, wdo_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int t0 = 0;
    int rise_at = -1;
    int fall_at = -1;
    int n_meas = 0;
    bit done = 0;

    always #10 clk = ~clk;

    supply_supervisor #(
        .STRETCH_CYC   (N),
        .MR_MIN_CYC    (M),
        .WD_TIMEOUT_CYC(T)
    ) dut (
        .clk      (clk),
        .por_n    (por_n),
        .supply_ok(supply_ok),
        .mr_n     (mr_n),
        .wd_strobe(wd_strobe),
        .rst_hi   (rst_hi),
        .rst_lo_n (rst_lo_n),
        .wdo_n    (wdo_n)
    );

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // advance to the next falling edge, check R2, track reset edges since t0
    task automatic step();
        @(negedge clk);
        cyc++;
        check_eq("R2 rst_lo_n complement", int'(rst_lo_n), int'(!rst_hi));
        if (rst_hi && rise_at < 0) rise_at = cyc - t0;
        if (!rst_hi && rise_at >= 0 && fall_at < 0) fall_at = cyc - t0;
    endtask

    task automatic mark();
        t0 = cyc;
        rise_at = -1;
        fall_at = -1;
    endtask

    task automatic until_rst(input logic lvl);
        n_meas = 0;
        do begin
            step();
            n_meas++;
        end while (rst_hi !== lvl && n_meas < 500);
    endtask

    task automatic until_wdo(input logic lvl);
        n_meas = 0;
        do begin
            step();
            n_meas++;
        end while (wdo_n !== lvl && n_meas < 500);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL bench timeout actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        por_n = 1'b0; supply_ok = 1'b1; mr_n = 1'b1; wd_strobe = 1'b0;
        repeat (3) step();
        check_eq("R1 rst_hi during power-on reset", int'(rst_hi), 1);
        check_eq("R1 rst_lo_n during power-on reset", int'(rst_lo_n), 0);

        por_n = 1'b1;
        until_rst(1'b0);
        check_eq("R1 release edges after por", n_meas, N + 3);

        // R11: counter held clear through the long power-up reset
        until_wdo(1'b0);
        check_eq("R11 expiry edges after reset release", n_meas, T + 1);

        wd_strobe = ~wd_strobe;
        until_wdo(1'b1);
        check_eq("R10 recovery edges after strobe toggle", n_meas, 3);

        // R9 sweep of strobe periods around the timeout
        for (int p = 1; p <= T + 2; p++) begin
            bit seen;
            seen = 0;
            wd_strobe = ~wd_strobe;
            repeat (4) step();
            for (int k = 0; k < 4; k++) begin
                wd_strobe = ~wd_strobe;
                for (int s = 0; s < p; s++) begin
                    step();
                    if (!wdo_n) seen = 1;
                end
            end
            check_eq($sformatf("R9 alarm seen for period %0d", p), int'(seen), int'(p > T));
        end

        wd_strobe = ~wd_strobe;
        repeat (4) step();
        wd_strobe = ~wd_strobe;
        until_wdo(1'b0);
        check_eq("R9 timeout edges after last toggle", n_meas, T + 3);

        // R8 / R3: supply loss with a freshly served watchdog
        wd_strobe = ~wd_strobe;
        repeat (4) step();
        check_eq("R8 alarm high before loss", int'(wdo_n), 1);
        supply_ok = 1'b0;
        step();
        check_eq("R8 alarm still high one edge after loss", int'(wdo_n), 1);
        step();
        check_eq("R8 alarm low two edges after loss", int'(wdo_n), 0);
        check_eq("R3 reset not yet raised at two edges", int'(rst_hi), 0);
        step();
        check_eq("R3 reset raised at three edges", int'(rst_hi), 1);
        begin
            int drops;
            drops = 0;
            repeat (10) begin
                step();
                if (!rst_hi) drops++;
            end
            check_eq("R3 reset held while supply bad", drops, 0);
        end
        supply_ok = 1'b1;
        until_rst(1'b0);
        check_eq("R4 release edges after supply return", n_meas, N + 3);

        // R5 / R6: manual reset width sweep
        for (int w = 1; w <= M + 2; w++) begin
            mark();
            mr_n = 1'b0;
            for (int s = 1; s <= w + N + 10; s++) begin
                step();
                if (s == w) mr_n = 1'b1;
            end
            if (w >= M) begin
                check_eq($sformatf("R5 rise edge for width %0d", w), rise_at, M + 3);
                check_eq($sformatf("R6 fall edge for width %0d", w), fall_at, w + 4 + N);
            end else begin
                check_eq($sformatf("R5 short width %0d rejected", w), rise_at, -1);
            end
        end

        // R7: short bounce pulses during the stretch
        begin
            int w;
            int drops;
            w = M + 1;
            drops = 0;
            mark();
            mr_n = 1'b0;
            repeat (w) step();
            mr_n = 1'b1;
            for (int b = 1; b < M; b++) begin
                repeat (2) step();
                mr_n = 1'b0;
                repeat (b) step();
                mr_n = 1'b1;
            end
            while ((cyc - t0) < w + N + 10) begin
                step();
                if (!rst_hi && (cyc - t0) < w + 4 + N) drops++;
            end
            check_eq("R7 no dropout during bounce", drops, 0);
            check_eq("R7 release edge unchanged by bounce", fall_at, w + 4 + N);
        end

        // R10: reset assertion clears an expired alarm
        until_wdo(1'b0);
        check_eq("R10 alarm expired before press", int'(wdo_n), 0);
        mr_n = 1'b0;
        repeat (M + 3) step();
        check_eq("R10 reset raised by press", int'(rst_hi), 1);
        check_eq("R10 alarm still low on reset edge", int'(wdo_n), 0);
        step();
        check_eq("R10 alarm high one edge after reset", int'(wdo_n), 1);
        mr_n = 1'b1;
        repeat (N + 8) step();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule